// File: doc/BRIEF.md
# Iterative Hamming distance unit

This block counts the bit positions in which two unsigned words differ. A caller presents both words together with a one-cycle start request while the unit is idle. On that clock edge the unit loads the bitwise XOR of the two words into a working register and clears its iteration counter.

On every following cycle the unit removes the lowest set bit of the working register, using the rule value AND (value minus one), and adds one to the counter. When the working register reaches zero, the unit publishes the count on its distance output and pulses done for one cycle. Busy is high for the whole time the unit is iterating.

Latency therefore follows the data. A result with d differing bits takes d+1 cycles after the start edge, so equal words finish in a single cycle. The distance output is registered and keeps its value until the next computation finishes.

Top module: `hamdist_iter`

## Requirements
- R1: While reset is high and on the first cycle after it, busy_o and done_o are 0 and dist_o is 0.
- R2: A start_i sampled high while busy_o is low is accepted: the operands are captured on that edge and busy_o reads 1 from that edge onward.
- R3: The published dist_o equals the number of set bits in op_a_i XOR op_b_i, as captured at the accepted start. For example, 7'b1011101 against 7'b1001001 gives 2.
- R4: With d differing bits, done_o goes high on the (d+1)-th rising edge after the accepting edge. busy_o stays 1 for exactly those d+1 cycles and falls on the same edge at which done_o rises.
- R5: When the two operands are equal, done_o rises on the edge right after the accepting edge and dist_o is 0.
- R6: A start_i that arrives while busy_o is 1 is ignored. Changes on op_a_i and op_b_i after the accepting edge have no effect on the result.
- R7: done_o is high for exactly one cycle per accepted start.
- R8: dist_o does not change except on the edge at which done_o rises. It therefore stays valid until after the next accepted start.
- R9: Operands that differ in all WIDTH bits give dist_o equal to WIDTH, with no overflow of the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, honoured only while idle |
| op_a_i | input | WIDTH | First operand |
| op_b_i | input | WIDTH | Second operand |
| busy_o | output | 1 | High while iterating |
| done_o | output | 1 | One-cycle pulse when the result is published |
| dist_o | output | $clog2(WIDTH)+1 | Number of differing bit positions |

## Verification
The bench targets four corner cases:
- Equal operands, where the loop runs zero times. A design that always iterates at least once would report 1 or finish a cycle late.
- All bits different. A counter one bit too narrow would wrap to zero here.
- Start requests and operand changes injected mid-iteration. A design that re-captures its inputs while busy would return the distance of the later operands, or stretch its latency.
- Cycle counting against the expected d+1 latency, which exposes off-by-one errors in the zero test. The same test also exposes a done signal held for more than one cycle.

// File: rtl/hd_pkg.sv
package hd_pkg;
  typedef enum logic {
    HD_IDLE = 1'b0,
    HD_RUN  = 1'b1
  } hd_state_t;
endpackage

// File: rtl/hd_clear_low.sv
module hd_clear_low #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] next_o,
  output logic         nz_o
);
  // Remove the lowest set bit of the working value.
  always_comb begin
    next_o = val_i & (val_i - W'(1));
    nz_o   = |val_i;
  end
endmodule

// File: rtl/hd_counter.sv
module hd_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) q_o <= '0;
    else if (inc_i)   q_o <= q_o + CW'(1);
  end
endmodule

// File: rtl/hd_ctrl.sv
module hd_ctrl
  import hd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic nz_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o
);
  hd_state_t state_q;

  always_comb begin
    load_o   = (state_q == HD_IDLE) && start_i;
    step_o   = (state_q == HD_RUN) && nz_i;
    finish_o = (state_q == HD_RUN) && !nz_i;
    busy_o   = (state_q == HD_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst)           state_q <= HD_IDLE;
    else if (load_o)   state_q <= HD_RUN;
    else if (finish_o) state_q <= HD_IDLE;
  end
endmodule

// File: rtl/hamdist_iter.sv
module hamdist_iter #(
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(WIDTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] dist_o
);
  logic [WIDTH-1:0] work_q;
  logic [WIDTH-1:0] work_next;
  logic             work_nz;
  logic             load;
  logic             step;
  logic             finish;
  logic [CNT_W-1:0] count;

  hd_clear_low #(.W(WIDTH)) u_clear (
    .val_i  (work_q),
    .next_o (work_next),
    .nz_o   (work_nz)
  );

  hd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .nz_i     (work_nz),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .busy_o   (busy_o)
  );

  hd_counter #(.CW(CNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .clr_i (load),
    .inc_i (step),
    .q_o   (count)
  );

  always_ff @(posedge clk) begin
    if (rst)       work_q <= '0;
    else if (load) work_q <= op_a_i ^ op_b_i;
    else if (step) work_q <= work_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      dist_o <= '0;
    end else begin
      done_o <= finish;
      if (finish) dist_o <= count;
    end
  end
endmodule

// File: rtl/hd_checker.sv
module hd_checker #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [WIDTH-1:0] op_a_i,
  input logic [WIDTH-1:0] op_b_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] dist_o
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_busy_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  p_dist_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(dist_o));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    dist_o <= CNT_W'(WIDTH));

  p_equal_fast_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_o) && $past(op_a_i == op_b_i)) |=> (done_o && dist_o == '0));
endmodule

bind hamdist_iter hd_checker #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .op_a_i  (op_a_i),
  .op_b_i  (op_b_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .dist_o  (dist_o)
);

// File: tb/hamdist_iter_test.sv
module hamdist_iter_test;
  localparam int WIDTH = 16;
  localparam int CNT_W = $clog2(WIDTH) + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [WIDTH-1:0] op_a_i = '0;
  logic [WIDTH-1:0] op_b_i = '0;
  logic             busy_o;
  logic             done_o;
  logic [CNT_W-1:0] dist_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hamdist_iter #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_a_i(op_a_i),
    .op_b_i(op_b_i), .busy_o(busy_o), .done_o(done_o), .dist_o(dist_o)
  );

  function automatic int bit_diff(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    int n = 0;
    for (int i = 0; i < WIDTH; i++) if (a[i] != b[i]) n++;
    return n;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Run one computation; when disturb is set, inject start pulses and
  // operand changes while busy.
  task automatic run(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, bit disturb);
    int d = bit_diff(a, b);
    int n = 0;
    int old = int'(dist_o);
    @(negedge clk);
    op_a_i = a; op_b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", int'(busy_o), 1);
    while (!done_o && n < 40) begin
      if (disturb) begin
        op_a_i = WIDTH'($urandom);
        op_b_i = WIDTH'($urandom);
        start_i = 1'($urandom);
      end
      if (!done_o) check("R8 dist held while busy", int'(dist_o), old);
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    check("R4 latency", n, d + 1);
    check("R4 busy low at done", int'(busy_o), 0);
    check("R3 distance", int'(dist_o), d);
    if (d == 0) check("R5 equal operands one cycle", n, 1);
    if (disturb) check("R6 result unaffected by busy start", int'(dist_o), d);
    op_a_i = WIDTH'($urandom);
    op_b_i = WIDTH'($urandom);
    @(negedge clk);
    check("R7 done one cycle", int'(done_o), 0);
    check("R8 dist holds after done", int'(dist_o), d);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy_o), 0);
    check("R1 done in reset", int'(done_o), 0);
    check("R1 dist in reset", int'(dist_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", int'(busy_o), 0);
    check("R1 dist after reset", int'(dist_o), 0);

    run(16'b1011101, 16'b1001001, 1'b0);    // R3 example gives 2
    run(16'h5A5A, 16'h5A5A, 1'b0);          // R5 equal
    run(16'h0000, 16'h0000, 1'b0);          // R5 zeros
    run(16'hFFFF, 16'h0000, 1'b0);          // R9 full width
    run(16'hAAAA, 16'h5555, 1'b1);          // R9 with R6 disturbance
    run(16'h8001, 16'h0000, 1'b1);          // R6 ends bits
    for (int k = 0; k < 40; k++)
      run(WIDTH'($urandom), WIDTH'($urandom), 1'($urandom));
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule